// File: doc/BRIEF.md
# Read-Sequence Store/Recall Command Detector

This block watches the completed accesses of a memory port and spots two
six-access unlock sequences made only of reads. The two sequences share the
same first five addresses. The sixth address selects the command: one value
requests a store to nonvolatile cells and the other requests a recall from
them. When a sequence completes, the block raises a one-cycle command pulse.
The memory array, the data bus and the work that carries out a command are
handled elsewhere.

The sequence must arrive in exact order. Any other read or any write in the
middle of it discards the progress made so far. Only the low fourteen address
bits are compared. While the external busy input is high, every access is
ignored and the progress count stays where it is. The store command does not
depend on whether any write has taken place, because the block does not track
writes at all. A progress count is brought out for debug.

Top module: `seq_cmd_detect`

## Requirements
- R1: Reset sets the progress count `seqStep` to 0 and holds both command outputs low.
- R2: Reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in that order, raise `seqStep` to 1, 2, 3, 4 and 5. The new value appears one clock after each read strobe. Cycles with no strobe leave `seqStep` unchanged.
- R3: A read of 0x0FC0 while `seqStep` is 5 pulses `storeCmd` high for exactly one cycle, one clock after the strobe, and returns `seqStep` to 0.
- R4: A read of 0x0C63 while `seqStep` is 5 pulses `recallCmd` high for exactly one cycle, one clock after the strobe, and returns `seqStep` to 0.
- R5: Only address bits 13..0 are compared. Bit 14 has no effect on matching at any step.
- R6: A read whose address does not match the next expected step, and is not 0x0E38, sets `seqStep` to 0 and issues no command.
- R7: A write strobe sets `seqStep` to 0 and issues no command. This includes a write to an address in the sequence.
- R8: A read of 0x0E38 that does not match the expected step sets `seqStep` to 1. This includes 0x0E38 at the sixth position.
- R9: While `busy` is high, read and write strobes are ignored. `seqStep` holds its value and no command is issued.
- R10: A read strobe and a write strobe in the same cycle are treated as a write.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | One-cycle pulse marking a completed chip-enable-controlled read |
| wrStrobe | input | 1 | One-cycle pulse marking a completed write |
| addr | input | 15 | Address of the access being strobed |
| busy | input | 1 | Ignore all accesses while high |
| storeCmd | output | 1 | One-cycle store command pulse |
| recallCmd | output | 1 | One-cycle recall command pulse |
| seqStep | output | 3 | Number of sequence steps matched so far (0 to 5) |

## Verification
Every result is registered once. The progress count and both command pulses
change at the first rising edge after the strobe cycle, so each result is due
one clock after its stimulus. The bench applies each vector at a falling edge
and reads the outputs one nanosecond after the next rising edge. It then
removes the strobes, so each strobe lasts exactly one cycle. Checking the
command pulses in the cycle after they appear confirms that each pulse lasts
only one cycle. Busy vectors check that the count is held across the ignored
cycle.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

  localparam int KEY_W = 14;

  typedef struct packed {
    logic advance;
    logic restart;
    logic clear;
    logic fireStore;
    logic fireRecall;
  } seqCtl_t;

  localparam logic [KEY_W-1:0] STORE_KEY  = 14'h0FC0;
  localparam logic [KEY_W-1:0] RECALL_KEY = 14'h0C63;

  function automatic logic [KEY_W-1:0] stepKey(input int idx);
    case (idx)
      0:       return 14'h0E38;
      1:       return 14'h31C7;
      2:       return 14'h03E0;
      3:       return 14'h3C1F;
      4:       return 14'h303F;
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/seqcmd_datapath.sv
module seqcmd_datapath
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int STEPS  = 6,
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  seqCtl_t           ctl,
  output logic [STEP_W-1:0] stepQ,
  output logic              keyHit,
  output logic              firstHit,
  output logic              storeHit,
  output logic              recallHit,
  output logic              storeCmd,
  output logic              recallCmd
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic [KEY_W-1:0] cmpAddr;
  assign cmpAddr = addr[KEY_W-1:0];

  assign keyHit    = (cmpAddr == stepKey(int'(stepQ)));
  assign firstHit  = (cmpAddr == stepKey(0));
  assign storeHit  = (cmpAddr == STORE_KEY);
  assign recallHit = (cmpAddr == RECALL_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ     <= '0;
      storeCmd  <= 1'b0;
      recallCmd <= 1'b0;
    end else begin
      storeCmd  <= ctl.fireStore;
      recallCmd <= ctl.fireRecall;
      if (ctl.clear || ctl.fireStore || ctl.fireRecall) stepQ <= '0;
      else if (ctl.restart)                             stepQ <= STEP_W'(1);
      else if (ctl.advance)                             stepQ <= stepQ + 1'b1;
    end
  end

  // R3 R4
  cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeCmd |-> !recallCmd);

  // R3
  store_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeCmd |-> ($past(stepQ) == LAST && stepQ == '0));

  // R4
  recall_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallCmd |-> ($past(stepQ) == LAST && stepQ == '0));

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepQ <= LAST);

endmodule

// File: rtl/seqcmd_control.sv
module seqcmd_control
  import seqcmd_pkg::*;
#(
  parameter int STEPS  = 6,
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              busy,
  input  logic [STEP_W-1:0] stepQ,
  input  logic              keyHit,
  input  logic              firstHit,
  input  logic              storeHit,
  input  logic              recallHit,
  input  logic              storeCmd,
  input  logic              recallCmd,
  output seqCtl_t           ctl
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  always_comb begin
    ctl = '0;
    if (!busy) begin
      if (wrStrobe) begin
        ctl.clear = 1'b1;
      end else if (rdStrobe) begin
        if (stepQ == LAST) begin
          if (storeHit)       ctl.fireStore  = 1'b1;
          else if (recallHit) ctl.fireRecall = 1'b1;
          else if (firstHit)  ctl.restart    = 1'b1;
          else                ctl.clear      = 1'b1;
        end else if (keyHit) begin
          ctl.advance = 1'b1;
        end else if (firstHit) begin
          ctl.restart = 1'b1;
        end else begin
          ctl.clear = 1'b1;
        end
      end
    end
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(stepQ) && !storeCmd && !recallCmd));

  // R7 R10
  write_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !busy) |=> (stepQ == '0 && !storeCmd && !recallCmd));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobe && !wrStrobe) |=> ($stable(stepQ) && !storeCmd && !recallCmd));

endmodule

// File: rtl/seq_cmd_detect.sv
module seq_cmd_detect
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int STEPS  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              storeCmd,
  output logic              recallCmd,
  output logic [$clog2(STEPS)-1:0] seqStep
);

  localparam int STEP_W = $clog2(STEPS);

  seqCtl_t           ctl;
  logic [STEP_W-1:0] stepQ;
  logic              keyHit, firstHit, storeHit, recallHit;

  seqcmd_datapath #(.ADDR_W(ADDR_W), .STEPS(STEPS), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .ctl(ctl), .stepQ(stepQ),
    .keyHit(keyHit), .firstHit(firstHit), .storeHit(storeHit),
    .recallHit(recallHit), .storeCmd(storeCmd), .recallCmd(recallCmd)
  );

  seqcmd_control #(.STEPS(STEPS), .STEP_W(STEP_W)) u_ctl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .busy(busy), .stepQ(stepQ), .keyHit(keyHit), .firstHit(firstHit),
    .storeHit(storeHit), .recallHit(recallHit), .storeCmd(storeCmd),
    .recallCmd(recallCmd), .ctl(ctl)
  );

  assign seqStep = stepQ;

endmodule

// File: tb/seq_cmd_detect_bench.sv
module seq_cmd_detect_bench;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic        bsy;
    logic [14:0] a;
    logic [2:0]  st;
    logic        sc;
    logic        rc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VECS [NV] = '{
    // R2 then R3: store sequence
    '{1,0,0,15'h0E38,1,0,0,2}, '{1,0,0,15'h31C7,2,0,0,2},
    '{1,0,0,15'h03E0,3,0,0,2}, '{1,0,0,15'h3C1F,4,0,0,2},
    '{1,0,0,15'h303F,5,0,0,2}, '{1,0,0,15'h0FC0,0,1,0,3},
    '{0,0,0,15'h0000,0,0,0,3},
    // R5 and R4: recall sequence with bit 14 set on some steps
    '{1,0,0,15'h4E38,1,0,0,5}, '{1,0,0,15'h31C7,2,0,0,5},
    '{1,0,0,15'h43E0,3,0,0,5}, '{1,0,0,15'h3C1F,4,0,0,5},
    '{1,0,0,15'h303F,5,0,0,5}, '{1,0,0,15'h4C63,0,0,1,4},
    '{0,0,0,15'h0000,0,0,0,4},
    // R6 wrong read
    '{1,0,0,15'h0E38,1,0,0,6}, '{1,0,0,15'h31C7,2,0,0,6},
    '{1,0,0,15'h1234,0,0,0,6}, '{1,0,0,15'h31C7,0,0,0,6},
    // R8 restart on 0x0E38
    '{1,0,0,15'h0E38,1,0,0,8}, '{1,0,0,15'h31C7,2,0,0,8},
    '{1,0,0,15'h0E38,1,0,0,8}, '{1,0,0,15'h31C7,2,0,0,8},
    '{1,0,0,15'h03E0,3,0,0,8},
    // R7 writes abort
    '{0,1,0,15'h3C1F,0,0,0,7}, '{1,0,0,15'h3C1F,0,0,0,7},
    '{0,1,0,15'h0E38,0,0,0,7},
    // R9 busy ignores accesses
    '{1,0,0,15'h0E38,1,0,0,9}, '{1,0,1,15'h31C7,1,0,0,9},
    '{0,1,1,15'h0000,1,0,0,9}, '{1,0,0,15'h31C7,2,0,0,9},
    '{1,0,0,15'h03E0,3,0,0,9}, '{1,0,0,15'h3C1F,4,0,0,9},
    '{1,0,0,15'h303F,5,0,0,9}, '{1,0,1,15'h0FC0,5,0,0,9},
    '{1,0,0,15'h0FC0,0,1,0,3},
    // R8 0x0E38 at the sixth position
    '{1,0,0,15'h0E38,1,0,0,8}, '{1,0,0,15'h31C7,2,0,0,8},
    '{1,0,0,15'h03E0,3,0,0,8}, '{1,0,0,15'h3C1F,4,0,0,8},
    '{1,0,0,15'h303F,5,0,0,8}, '{1,0,0,15'h0E38,1,0,0,8},
    // R10 simultaneous read and write
    '{1,1,0,15'h31C7,0,0,0,10},
    // R2 idle cycle holds progress
    '{1,0,0,15'h0E38,1,0,0,2}, '{0,0,0,15'h31C7,1,0,0,2},
    '{1,0,0,15'h31C7,2,0,0,2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdStrobe = 1'b0, wrStrobe = 1'b0, busy = 1'b0;
  logic [14:0] addr = '0;
  logic        storeCmd, recallCmd;
  logic [2:0]  seqStep;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  seq_cmd_detect u_seq_cmd_detect (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .addr(addr), .busy(busy), .storeCmd(storeCmd), .recallCmd(recallCmd),
    .seqStep(seqStep)
  );

  task automatic checkOut(input int req, input logic [2:0] st,
                          input logic sc, input logic rc);
    nChecks++;
    if (seqStep !== st || storeCmd !== sc || recallCmd !== rc) begin
      nFails++;
      $display("FAIL R%0d: step/store/recall = %0d/%0b/%0b expected %0d/%0b/%0b",
               req, seqStep, storeCmd, recallCmd, st, sc, rc);
    end
  endtask

  task automatic applyVec(input vec_t v);
    @(negedge clk);
    rdStrobe = v.rd; wrStrobe = v.wr; busy = v.bsy; addr = v.a;
    @(posedge clk); #1;
    rdStrobe = 1'b0; wrStrobe = 1'b0; busy = 1'b0;
    checkOut(int'(v.req), v.st, v.sc, v.rc);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkOut(1, 3'd0, 1'b0, 1'b0);  // R1 reset state
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < NV; i++) applyVec(VECS[i]);
    // R1 reset in mid-sequence clears progress
    applyVec('{1,0,0,15'h03E0,3,0,0,2});
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    checkOut(1, 3'd0, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b1;
    // R3 store with bit 14 set on the final address
    applyVec('{1,0,0,15'h0E38,1,0,0,3});
    applyVec('{1,0,0,15'h31C7,2,0,0,3});
    applyVec('{1,0,0,15'h03E0,3,0,0,3});
    applyVec('{1,0,0,15'h3C1F,4,0,0,3});
    applyVec('{1,0,0,15'h303F,5,0,0,3});
    applyVec('{1,0,0,15'h4FC0,0,1,0,5});
    applyVec('{0,0,0,15'h0000,0,0,0,3});
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: run incomplete, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule